// File: doc/BRIEF.md
# NAND Hamming ECC generator

This block sits beside the byte stream of a NAND flash data path and builds a Hamming-style check code while page data passes through. It watches a byte-valid strobe and the byte on the same cycle, and keeps one running count of the bytes accepted since the last clear. Every accepted byte folds into a pair of 11-bit registers. The even register is the XOR of the position numbers of all set data bits, where a position is the byte index within its 256-byte chunk times eight plus the bit index. The odd register is the XOR of the bitwise complements of those same positions. Software packs a pair into a 22-bit code, even register in the low eleven bits, and stores it as three bytes, low byte first.

A mode input selects 256-byte or 512-byte chunks. In 256-byte mode only the first register pair moves. In 512-byte mode the first 256 accepted bytes feed the first pair and the next 256 feed the second pair, with the byte index restarting at zero. Once the selected number of bytes has been taken, further bytes are ignored until the next clear. A clear pulse must be given before every page. It zeroes the byte count and all four registers, and it overrides a byte that arrives in the same cycle.

A reader recomputes the code over the data it received and compares it with the stored code. When exactly one data bit has flipped, the XOR of the even-register difference and the odd-register difference is all ones (0x7FF). The even-register difference then gives the failing bit's position.

Top module: `nand_hamming_ecc`

## Requirements
- R1: While rst_n is low, and on the cycle after cnt_clr is high, ecc0, ecc1, ecc2 and ecc3 are all zero.
- R2: ecc0 equals the XOR over every set bit of the first chunk of the 11-bit value (byte index × 8 + bit index), where byte index is 0 to 255 and bit 0 is the least significant bit of byte_dat.
- R3: ecc1 equals the XOR over every set bit of the first chunk of the bitwise complement (in 11 bits) of that bit's position.
- R4: A byte taken at a rising clock edge is reflected in the registers right after that edge. A cycle with byte_vld low leaves all registers unchanged.
- R5: With mode512 high, accepted bytes 256 to 511 update only ecc2 (even) and ecc3 (odd), with the byte index counted from 0 again. Bytes 0 to 255 update only ecc0 and ecc1.
- R6: With mode512 low, ecc2 and ecc3 stay zero, and bytes offered after the 256th accepted byte change no register.
- R7: With mode512 high, bytes offered after the 512th accepted byte change no register. mode512 is held steady between clears.
- R8: When cnt_clr and byte_vld are high in the same cycle, the clear wins: the byte is dropped, and the next accepted byte is byte 0 of chunk 0.
- R9: If exactly one data bit of a chunk differs between two streams, (ecc0 XOR ecc0') XOR (ecc1 XOR ecc1') is 0x7FF, and ecc0 XOR ecc0' is the flipped bit's position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_clr | input | 1 | Per-page clear of the byte count and all ECC registers |
| mode512 | input | 1 | 1: two 256-byte chunks per transfer; 0: one chunk |
| byte_vld | input | 1 | byte_dat carries a data byte this cycle |
| byte_dat | input | 8 | Data byte |
| ecc0 | output | 11 | First chunk, even parities (XOR of positions) |
| ecc1 | output | 11 | First chunk, odd parities (XOR of complemented positions) |
| ecc2 | output | 11 | Second chunk, even parities |
| ecc3 | output | 11 | Second chunk, odd parities |

## Verification
The clear and the byte fold can fall in the same cycle. The bench provokes this by raising cnt_clr together with byte_vld, both partway through a chunk and on the boundary where the count has just filled. It judges the result on the next cycle: all four registers must be zero. It then checks that the byte that follows lands at index 0 of the first chunk, which shows that the dropped byte neither advanced the count nor left a trace in any register.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int ECC_CHUNK_BYTES = 256;
  localparam int ECC_NUM_CHUNKS  = 2;
  localparam int ECC_IDX_W       = $clog2(ECC_CHUNK_BYTES);
  localparam int ECC_POS_W       = ECC_IDX_W + 3;
  localparam int ECC_CNT_W       = $clog2(ECC_CHUNK_BYTES * ECC_NUM_CHUNKS) + 1;

  typedef struct packed {
    logic [ECC_POS_W-1:0] even;
    logic [ECC_POS_W-1:0] odd;
  } ecc_pair_t;

  // Contribution of one byte at a given index within its chunk.
  function automatic ecc_pair_t ecc_fold_byte(input logic [7:0] d,
                                              input logic [ECC_IDX_W-1:0] idx);
    ecc_pair_t r;
    logic [ECC_POS_W-1:0] p;
    r = '0;
    for (int b = 0; b < 8; b++) begin
      p = {idx, 3'(b)};
      if (d[b]) begin
        r.even = r.even ^ p;
        r.odd  = r.odd ^ ~p;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_byte_seq.sv
module ecc_byte_seq
  import nand_ecc_pkg::*;
#(
  parameter int CHUNK_BYTES = ECC_CHUNK_BYTES,
  parameter int NUM_CHUNKS  = ECC_NUM_CHUNKS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          mode_all,
  input  logic                          byte_vld,
  output logic [NUM_CHUNKS-1:0]         upd,
  output logic [$clog2(CHUNK_BYTES)-1:0] idx,
  output logic                          full
);
  localparam int IDX_W = $clog2(CHUNK_BYTES);
  localparam int CNT_W = $clog2(CHUNK_BYTES * NUM_CHUNKS) + 1;
  localparam logic [CNT_W-1:0] LIM_ONE = CNT_W'(CHUNK_BYTES);
  localparam logic [CNT_W-1:0] LIM_ALL = CNT_W'(CHUNK_BYTES * NUM_CHUNKS);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] chunk_sel;
  logic             accept;

  assign limit     = mode_all ? LIM_ALL : LIM_ONE;
  assign full      = (cnt >= limit);
  assign accept    = byte_vld && !clr && !full;
  assign idx       = cnt[IDX_W-1:0];
  assign chunk_sel = cnt >> IDX_W;

  for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_upd
    assign upd[g] = accept && (chunk_sel == CNT_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (accept)   cnt <= cnt + 1'b1;
  end

  AST_ONE_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd)); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM_ALL); // R7
  AST_CLR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R8
endmodule

// File: rtl/ecc_byte_fold.sv
module ecc_byte_fold
  import nand_ecc_pkg::*;
(
  input  logic [7:0]           dat,
  input  logic [ECC_IDX_W-1:0] idx,
  output logic [ECC_POS_W-1:0] even,
  output logic [ECC_POS_W-1:0] odd
);
  ecc_pair_t f;
  always_comb f = ecc_fold_byte(dat, idx);
  assign even = f.even;
  assign odd  = f.odd;

  AST_FOLD_ZERO: assert property (@(dat) (dat == 8'h00) |-> (even == '0 && odd == '0)); // R2
endmodule

// File: rtl/ecc_pair_acc.sv
module ecc_pair_acc
  import nand_ecc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 upd,
  input  logic [ECC_POS_W-1:0] fold_even,
  input  logic [ECC_POS_W-1:0] fold_odd,
  output logic [ECC_POS_W-1:0] q_even,
  output logic [ECC_POS_W-1:0] q_odd
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      q_even <= '0;
      q_odd  <= '0;
    end else if (upd) begin
      q_even <= q_even ^ fold_even;
      q_odd  <= q_odd ^ fold_odd;
    end
  end

  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q_even == '0 && q_odd == '0)); // R1
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !clr) |=> ($stable(q_even) && $stable(q_odd))); // R4
endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc
  import nand_ecc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cnt_clr,
  input  logic        mode512,
  input  logic        byte_vld,
  input  logic [7:0]  byte_dat,
  output logic [10:0] ecc0,
  output logic [10:0] ecc1,
  output logic [10:0] ecc2,
  output logic [10:0] ecc3
);
  logic [ECC_NUM_CHUNKS-1:0] upd;
  logic [ECC_IDX_W-1:0]      idx;
  logic                      page_full;
  logic [ECC_POS_W-1:0]      fold_even, fold_odd;
  logic [ECC_POS_W-1:0]      acc_even [ECC_NUM_CHUNKS];
  logic [ECC_POS_W-1:0]      acc_odd  [ECC_NUM_CHUNKS];

  ecc_byte_seq #(
    .CHUNK_BYTES(ECC_CHUNK_BYTES),
    .NUM_CHUNKS (ECC_NUM_CHUNKS)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cnt_clr),
    .mode_all(mode512),
    .byte_vld(byte_vld),
    .upd     (upd),
    .idx     (idx),
    .full    (page_full)
  );

  ecc_byte_fold u_fold (
    .dat (byte_dat),
    .idx (idx),
    .even(fold_even),
    .odd (fold_odd)
  );

  for (genvar g = 0; g < ECC_NUM_CHUNKS; g++) begin : g_pair
    ecc_pair_acc u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (cnt_clr),
      .upd      (upd[g]),
      .fold_even(fold_even),
      .fold_odd (fold_odd),
      .q_even   (acc_even[g]),
      .q_odd    (acc_odd[g])
    );
  end

  assign ecc0 = acc_even[0];
  assign ecc1 = acc_odd[0];
  assign ecc2 = acc_even[1];
  assign ecc3 = acc_odd[1];

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (page_full && !cnt_clr) |=> ($stable(ecc0) && $stable(ecc1) &&
                                 $stable(ecc2) && $stable(ecc3))); // R7
  AST_PAIR2_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode512 && !cnt_clr) |=> ($stable(ecc2) && $stable(ecc3))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_vld && !cnt_clr) |=> ($stable(ecc0) && $stable(ecc2))); // R4
endmodule

// File: tb/nand_hamming_ecc_test.sv
`timescale 1ns/1ps
module nand_hamming_ecc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_clr = 1'b0;
  logic        mode512 = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_dat = 8'h00;
  logic [10:0] ecc0, ecc1, ecc2, ecc3;

  always #2.5 clk = ~clk;

  nand_hamming_ecc uut (
    .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .mode512(mode512),
    .byte_vld(byte_vld), .byte_dat(byte_dat),
    .ecc0(ecc0), .ecc1(ecc1), .ecc2(ecc2), .ecc3(ecc3)
  );

  typedef struct {
    logic [10:0] e0, e1, e2, e3;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;
  int          m_cnt = 0;
  logic [10:0] m_e [4];

  task automatic check4(input logic [10:0] a0, a1, a2, a3, input exp_t x);
    n_checks++;
    if (a0 !== x.e0 || a1 !== x.e1 || a2 !== x.e2 || a3 !== x.e3) begin
      n_errors++;
      $display("FAIL %s: got %h %h %h %h expected %h %h %h %h",
               x.tag, a0, a1, a2, a3, x.e0, x.e1, x.e2, x.e3);
    end
  endtask

  task automatic check1(input logic [10:0] act, input logic [10:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Model: for each ECC bit k, parity of data bits whose position has bit k set (even)
  // or clear (odd).
  task automatic model_step(input logic v, input logic [7:0] d, input logic c);
    int lim, ch, idx, pos;
    lim = mode512 ? 512 : 256;
    if (c) begin
      m_cnt = 0;
      foreach (m_e[i]) m_e[i] = '0;
    end else if (v && m_cnt < lim) begin
      ch  = m_cnt / 256;
      idx = m_cnt % 256;
      for (int b = 0; b < 8; b++) begin
        if (d[b]) begin
          pos = idx * 8 + b;
          for (int k = 0; k < 11; k++) begin
            if ((pos >> k) & 1) m_e[2*ch][k]   = ~m_e[2*ch][k];
            else                m_e[2*ch+1][k] = ~m_e[2*ch+1][k];
          end
        end
      end
      m_cnt++;
    end
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic c, input string tag);
    exp_t x;
    @(negedge clk);
    byte_vld = v;
    byte_dat = d;
    cnt_clr  = c;
    model_step(v, d, c);
    x.e0 = m_e[0]; x.e1 = m_e[1]; x.e2 = m_e[2]; x.e3 = m_e[3]; x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic drain();
    step(1'b0, 8'h00, 1'b0, "R4");
    @(negedge clk);
    byte_vld = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 29 + seed * 7) ^ (i >> 2) ^ seed);
  endfunction

  // Monitor: compares the registered outputs just after each edge.
  initial begin
    exp_t x;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        x = sb.pop_front();
        check4(ecc0, ecc1, ecc2, ecc3, x);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [10:0] a0, a1, b0, b1;
    exp_t z;
    z.e0 = '0; z.e1 = '0; z.e2 = '0; z.e3 = '0; z.tag = "R1 reset";
    foreach (m_e[i]) m_e[i] = '0;
    repeat (4) @(posedge clk);
    #1 check4(ecc0, ecc1, ecc2, ecc3, z);
    @(negedge clk) rst_n = 1'b1;

    // R2 R3 R4: 256-byte chunk with gaps
    step(1'b0, 8'h00, 1'b1, "R1 clr");
    for (int i = 0; i < 256; i++) begin
      step(1'b1, pat(i, 3), 1'b0, "R2 R3 fold");
      if (i % 17 == 0) step(1'b0, 8'hFF, 1'b0, "R4 idle");
    end
    // R6: bytes beyond chunk ignored in 256 mode
    for (int i = 0; i < 6; i++) step(1'b1, 8'hA5, 1'b0, "R6 past end");
    drain();

    // Single set bit at known position: byte 5, bit 3 -> pos 43
    step(1'b0, 8'h00, 1'b1, "R1 clr");
    for (int i = 0; i < 5; i++) step(1'b1, 8'h00, 1'b0, "R2 zero byte");
    step(1'b1, 8'h08, 1'b0, "R2 R3 single bit");
    drain();
    check1(ecc0, 11'd43, "R2 pos");
    check1(ecc1, ~11'd43, "R3 complement");

    // R5 R7: 512-byte mode, all ones bytes and patterns, overflow bytes
    step(1'b0, 8'h00, 1'b1, "R1 clr");
    @(negedge clk) mode512 = 1'b1;
    step(1'b0, 8'h00, 1'b1, "R1 clr");
    for (int i = 0; i < 512; i++) step(1'b1, (i < 40) ? 8'hFF : pat(i, 11), 1'b0, "R5 two chunks");
    for (int i = 0; i < 5; i++) step(1'b1, 8'h3C, 1'b0, "R7 past end");
    // R8: clear and byte together when full, then byte 0 again
    step(1'b1, 8'h81, 1'b1, "R8 clr wins");
    step(1'b1, 8'h01, 1'b0, "R8 restart at byte 0");
    for (int i = 0; i < 30; i++) step(1'b1, pat(i, 5), 1'b0, "R5 partial");
    step(1'b1, 8'h77, 1'b1, "R8 clr mid chunk");
    step(1'b1, 8'h02, 1'b0, "R8 restart");
    drain();
    check1(ecc0, 11'd1, "R8 byte0 bit1");

    // R9: single flipped bit between two streams
    step(1'b0, 8'h00, 1'b1, "R1 clr");
    @(negedge clk) mode512 = 1'b0;
    for (int i = 0; i < 256; i++) step(1'b1, pat(i, 9), 1'b0, "R9 stream a");
    drain();
    a0 = ecc0; a1 = ecc1;
    step(1'b0, 8'h00, 1'b1, "R1 clr");
    for (int i = 0; i < 256; i++)
      step(1'b1, (i == 77) ? (pat(i, 9) ^ 8'h20) : pat(i, 9), 1'b0, "R9 stream b");
    drain();
    b0 = ecc0; b1 = ecc1;
    check1((a0 ^ b0) ^ (a1 ^ b1), 11'h7FF, "R9 syndrome");
    check1(a0 ^ b0, 11'(77 * 8 + 5), "R9 locate");

    drain();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule